// File: doc/BRIEF.md
# Eight-Pin Bit I/O Controller with Pattern Test Flags

This block is a general-purpose bit I/O controller for eight pins. Each pin has its own direction bit, so it acts either as an input or as an output. Output values sit in an output register. Single-cycle commands change that register, and each command carries an 8-bit mask. The set command forces the masked bits high, the clear command forces them low, and the toggle command inverts them. Bits outside the mask are left alone.

Input pins pass through a two-stage synchronizer. A readback vector shows the synchronized level for each input pin and the driven level for each output pin. A processor can give a group of pins (a test mask) and a bit pattern. One cycle later the block returns two condition flags: "every selected input matches the pattern" and "at least one selected input matches the pattern". Any selected pin that is configured as an output is dropped from the test. Pad drivers and pin sharing with other peripherals are outside this block.

Top module: `bitio_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `pin_oe`, `pin_out`, `pin_state`, `flag_all` and `flag_any` are all 0. The reset makes every pin an input and clears the output register and the synchronizer.
- R2: When `dir_we` is high at a clock edge, the direction register loads `dir_wdata`. `pin_oe` shows that register, and bit value 1 means output. The register holds its value while `dir_we` is low.
- R3: A set command (`cmd_set`) ORs `cmd_mask` into the output register at the next edge. With no command active, the output register holds its value.
- R4: A clear command (`cmd_clr`) ANDs the inverse of `cmd_mask` into the output register at the next edge.
- R5: A toggle command (`cmd_tgl`) XORs `cmd_mask` into the output register at the next edge.
- R6: When several commands are raised in the same cycle, only the highest-priority one takes effect. Clear ranks above set, and set ranks above toggle.
- R7: `pin_out` always equals the output register, whatever the direction bits are.
- R8: A level on `pin_in` for an input-direction pin appears on `pin_state` after exactly two clock edges.
- R9: For an output-direction pin, `pin_state` equals that pin's output register bit.
- R10: `flag_all` is registered from the values before the edge. It is 1 when every bit of the effective test mask has `pin_state` equal to `test_pat`. It is also 1 when the effective mask is empty.
- R11: `flag_any` is registered from the values before the edge. It is 1 when at least one bit of the effective test mask has `pin_state` equal to `test_pat`. It is 0 when the effective mask is empty.
- R12: The effective test mask is `test_mask` with every output-direction bit removed. Selecting an output pin therefore never changes either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | 8 | New direction bits (1 = output) |
| cmd_set | input | 1 | Set command |
| cmd_clr | input | 1 | Clear command |
| cmd_tgl | input | 1 | Toggle command |
| cmd_mask | input | 8 | Bit mask used by the command |
| pin_in | input | 8 | Raw levels from the pads |
| pin_out | output | 8 | Output register value to the pads |
| pin_oe | output | 8 | Per-pin output enable (direction) |
| pin_state | output | 8 | Readback: synchronized input or driven value |
| test_mask | input | 8 | Pins selected for the pattern test |
| test_pat | input | 8 | Pattern compared against the selected pins |
| flag_all | output | 1 | All effective selected pins match |
| flag_any | output | 1 | At least one effective selected pin matches |

## Verification
The hardest situation to reach from the ports combines three things in one cycle. The test mask selects pins of both directions. A just-flipped direction bit still has a stale value in the synchronizer. A multi-command cycle is changing the output register. Only with all three does the exclusion of output pins and the command priority both show up at the flags. The stimulus writes random direction words often and raises random combinations of the three command strobes with random masks. It drives random pad levels and random test masks and patterns. A behavioural model built from integer arithmetic is compared with every output at every clock. Directed sequences cover the cases that random stimulus rarely hits: all three commands at once, an empty effective mask, and a mask that selects only output pins.

// File: rtl/bitio_pkg.sv
package bitio_pkg;

    localparam int BIO_PINS        = 8;
    localparam int BIO_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_CLR  = 2'd1,
        OP_SET  = 2'd2,
        OP_TGL  = 2'd3
    } bio_op_e;

    typedef struct packed {
        logic all_match;
        logic any_match;
    } bio_flags_t;

    // Clear outranks set, set outranks toggle.
    function automatic bio_op_e pick_op(input logic set_i,
                                        input logic clr_i,
                                        input logic tgl_i);
        bio_op_e op;
        if (clr_i)      op = OP_CLR;
        else if (set_i) op = OP_SET;
        else if (tgl_i) op = OP_TGL;
        else            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/bitio_sync.sv
module bitio_sync #(
    parameter int W      = bitio_pkg::BIO_PINS,
    parameter int STAGES = bitio_pkg::BIO_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];
    logic         live;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
            // R8: each stage carries the previous stage one edge later
            p_stage_shift_r8: assert property (@(posedge clk) disable iff (rst)
                live |-> stg[i] == $past(stg[i-1]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    assign q = stg[LAST];

    // R8: first stage captures the pad level
    p_first_capture_r8: assert property (@(posedge clk) disable iff (rst)
        live |-> stg[0] == $past(d));

endmodule

// File: rtl/bitio_outreg.sv
module bitio_outreg
    import bitio_pkg::*;
#(
    parameter int W = BIO_PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic         tgl_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] q
);
    bio_op_e      op;
    logic [W-1:0] nxt;

    always_comb begin
        op = pick_op(set_i, clr_i, tgl_i);
        unique case (op)
            OP_CLR:  nxt = q & ~mask_i;
            OP_SET:  nxt = q | mask_i;
            OP_TGL:  nxt = q ^ mask_i;
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R4 and R6: clear always wins, masked bits end low
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (q & $past(mask_i)) == '0);
    // R3: set without clear leaves masked bits high, others unchanged
    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> q == ($past(q) | $past(mask_i)));
    // R5: a lone toggle flips exactly the masked bits
    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (tgl_i && !set_i && !clr_i) |=> q == ($past(q) ^ $past(mask_i)));
    // R3: no command keeps the register
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tgl_i && !set_i && !clr_i) |=> $stable(q));

endmodule

// File: rtl/bitio_pattest.sv
module bitio_pattest
    import bitio_pkg::*;
#(
    parameter int W = BIO_PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] tmask_i,
    input  logic [W-1:0] tpat_i,
    output bio_flags_t   flags_o
);
    logic [W-1:0] eff_mask;
    logic [W-1:0] hit;
    bio_flags_t   flags_d;

    assign eff_mask = tmask_i & ~dir_i;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            assign hit[b] = eff_mask[b] & (state_i[b] ~^ tpat_i[b]);
        end
    endgenerate

    always_comb begin
        flags_d.all_match = (hit == eff_mask);
        flags_d.any_match = |hit;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= flags_d;
    end

    // R10/R11: empty effective mask gives all=1, any=0
    p_empty_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (eff_mask == '0) |=> (flags_o.all_match && !flags_o.any_match));
    // R11: with a non-empty mask, full match implies some match
    p_all_implies_any_r11: assert property (@(posedge clk) disable iff (rst)
        (eff_mask != '0) |=> (!flags_o.all_match || flags_o.any_match));
    // R12: output-direction pins never take part in the test
    p_out_pins_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        ((tmask_i & ~dir_i) == '0) |=> !flags_o.any_match);

endmodule

// File: rtl/bitio_ctrl.sv
module bitio_ctrl
    import bitio_pkg::*;
#(
    parameter int NPINS       = BIO_PINS,
    parameter int SYNC_STAGES = BIO_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_we,
    input  logic [NPINS-1:0] dir_wdata,
    input  logic             cmd_set,
    input  logic             cmd_clr,
    input  logic             cmd_tgl,
    input  logic [NPINS-1:0] cmd_mask,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_state,
    input  logic [NPINS-1:0] test_mask,
    input  logic [NPINS-1:0] test_pat,
    output logic             flag_all,
    output logic             flag_any
);
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] sync_q;
    bio_flags_t       flags;

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (dir_we) dir_q <= dir_wdata;
    end

    bitio_outreg #(.W(NPINS)) u_outreg (
        .clk    (clk),
        .rst    (rst),
        .set_i  (cmd_set),
        .clr_i  (cmd_clr),
        .tgl_i  (cmd_tgl),
        .mask_i (cmd_mask),
        .q      (out_q)
    );

    bitio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_q)
    );

    assign pin_state = (out_q & dir_q) | (sync_q & ~dir_q);

    bitio_pattest #(.W(NPINS)) u_test (
        .clk     (clk),
        .rst     (rst),
        .state_i (pin_state),
        .dir_i   (dir_q),
        .tmask_i (test_mask),
        .tpat_i  (test_pat),
        .flags_o (flags)
    );

    assign pin_out  = out_q;
    assign pin_oe   = dir_q;
    assign flag_all = flags.all_match;
    assign flag_any = flags.any_match;

    // R2: direction register follows its write strobe
    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        dir_we |=> pin_oe == $past(dir_wdata));
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !dir_we |=> $stable(pin_oe));
    // R9: output-direction pins read back their driven value
    p_readback_r9: assert property (@(posedge clk) disable iff (rst)
        ((pin_state ^ pin_out) & pin_oe) == '0);

endmodule

// File: tb/sim_bitio_ctrl.sv
module sim_bitio_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_we = 1'b0;
    logic [7:0] dir_wdata = '0;
    logic       cmd_set = 1'b0, cmd_clr = 1'b0, cmd_tgl = 1'b0;
    logic [7:0] cmd_mask = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] test_mask = '0, test_pat = '0;
    logic [7:0] pin_out, pin_oe, pin_state;
    logic       flag_all, flag_any;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bitio_ctrl u0 (
        .clk(clk), .rst(rst), .dir_we(dir_we), .dir_wdata(dir_wdata),
        .cmd_set(cmd_set), .cmd_clr(cmd_clr), .cmd_tgl(cmd_tgl),
        .cmd_mask(cmd_mask), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_state(pin_state), .test_mask(test_mask),
        .test_pat(test_pat), .flag_all(flag_all), .flag_any(flag_any)
    );

    // Behavioural reference model
    int m_dir, m_out, m_s1, m_s2, m_all, m_any;

    function automatic int m_state();
        return (m_out & m_dir) | (m_s2 & ~m_dir & 255);
    endfunction

    always @(posedge clk) begin
        int st, em, n_all, n_any;
        if (rst) begin
            m_dir <= 0; m_out <= 0; m_s1 <= 0; m_s2 <= 0;
            m_all <= 0; m_any <= 0;
        end else begin
            st = m_state();
            em = test_mask & ~m_dir & 255;
            n_all = 1; n_any = 0;
            for (int b = 0; b < 8; b++) begin
                if (em[b]) begin
                    if (st[b] == test_pat[b]) n_any = 1;
                    else                      n_all = 0;
                end
            end
            m_all <= n_all;
            m_any <= n_any;
            if (dir_we) m_dir <= dir_wdata;
            if (cmd_clr)      m_out <= m_out & ~cmd_mask & 255;
            else if (cmd_set) m_out <= m_out | cmd_mask;
            else if (cmd_tgl) m_out <= m_out ^ cmd_mask;
            m_s1 <= pin_in;
            m_s2 <= m_s1;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 pin_oe", pin_oe, m_dir);
        check("R3/R4/R5/R6/R7 pin_out", pin_out, m_out);
        check("R8/R9 pin_state", pin_state, m_state());
        check("R10/R12 flag_all", flag_all, m_all);
        check("R11/R12 flag_any", flag_any, m_any);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        dir_we = 0; cmd_set = 0; cmd_clr = 0; cmd_tgl = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        pin_in = 8'h5A;
        repeat (3) step();
        // R1: reset state
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_state", pin_state, 0);
        check("R1 flags", {flag_all, flag_any}, 0);
        rst = 0;
        step();
        check("R1 first cycle out", pin_out, 0);
        check("R1 first cycle state", pin_state, 0);

        // R2: low nibble outputs
        dir_we = 1; dir_wdata = 8'h0F;
        step();
        idle();
        check("R2 direction", pin_oe, 8'h0F);
        // R3: set all
        cmd_set = 1; cmd_mask = 8'hFF;
        step();
        idle();
        check("R3 set all", pin_out, 8'hFF);
        // R6: all three at once, clear wins
        cmd_set = 1; cmd_clr = 1; cmd_tgl = 1; cmd_mask = 8'h3C;
        step();
        idle();
        check("R6 clear wins", pin_out, 8'hC3);
        // R6: set beats toggle
        cmd_set = 1; cmd_tgl = 1; cmd_mask = 8'h0C;
        step();
        idle();
        check("R6 set over toggle", pin_out, 8'hCF);
        // R5: toggle alone
        cmd_tgl = 1; cmd_mask = 8'h81;
        step();
        idle();
        check("R5 toggle", pin_out, 8'h4E);
        // R8: input timing
        pin_in = 8'hA0;
        step();
        check("R8 not yet after one edge", pin_state & 8'hF0, 8'h50);
        step();
        check("R8 visible after two edges", pin_state, 8'hAE);
        // R9: output pins read back driven value
        check("R9 readback", pin_state & 8'h0F, 8'h0E);
        // R10/R11: full match
        test_mask = 8'hF0; test_pat = 8'hA0;
        step();
        check("R10 all match", flag_all, 1);
        check("R11 any match", flag_any, 1);
        // R11: one mismatch keeps any, drops all
        test_pat = 8'hB0;
        step();
        check("R10 partial", flag_all, 0);
        check("R11 partial", flag_any, 1);
        // R12: mask only on output pins with wrong pattern
        test_mask = 8'h0F; test_pat = 8'h00;
        step();
        check("R12 out pins ignored all", flag_all, 1);
        check("R12 out pins ignored any", flag_any, 0);
        // R10: empty mask
        test_mask = 8'h00;
        step();
        check("R10 empty mask", {flag_all, flag_any}, 2'b10);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            dir_we    = ($urandom_range(0, 7) == 0);
            dir_wdata = 8'($urandom);
            cmd_set   = $urandom_range(0, 2) == 0;
            cmd_clr   = $urandom_range(0, 3) == 0;
            cmd_tgl   = $urandom_range(0, 2) == 0;
            cmd_mask  = 8'($urandom);
            if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
            test_mask = 8'($urandom);
            test_pat  = ($urandom_range(0, 1) == 0) ? pin_state : 8'($urandom);
            step();
        end
        idle();
        // R1: reset again mid-run
        rst = 1;
        step();
        check("R1 re-reset out", pin_out, 0);
        check("R1 re-reset oe", pin_oe, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule